// File: doc/BRIEF.md
# Multiplexed Parallel Bus Master Sequencer

This block is the host-side engine for a 16-bit multiplexed address/data bus. A transfer request carries a 32-bit physical address, a direction and a word count. The sequencer decodes the address into one of two timing domains, or rejects it. It puts the upper and then the lower address half on the shared pins, each with its own active-low latch strobe. It then moves the requested number of words, each paced by three programmable 8-bit phases: a wait before the strobe, the strobe's low time and a recovery time with the strobe high.

Requests enter on a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request that is held with `req_valid` must stay unchanged until it is taken. Write words arrive on a second valid/ready stream. When no word is offered, the wait phase of the current word stretches until one is. Read words leave on a single-entry valid/ready output. If an earlier read word has not been taken, the next strobe low phase is held off, so no read word is ever lost. Each domain's three timing values are set through a small write-only register port.

Top module: `pbus_seq`

## Requirements
- R1: Addresses 0x0500_0000–0x05FF_FFFF and 0x0800_0000–0x0FFF_FFFF use the timing of domain B. Addresses 0x0600_0000–0x07FF_FFFF, 0x1000_0000–0x1FBF_FFFF and 0x1FD0_0000–0x7FFF_FFFF use the timing of domain A.
- R2: Any other address is accepted and answered in the next cycle by a one-cycle `done` together with `done_err`. No latch strobe, read strobe or write strobe moves, and the bus is not driven.
- R3: After a request is accepted, the address phase takes four cycles, all with the bus driven. In cycle 1, `ale_hi_n` is high and the bus carries address bits 31:16. In cycle 2, `ale_hi_n` goes low and the bus still carries bits 31:16. In cycle 3, `ale_lo_n` is high and the bus carries bits 15:0. In cycle 4, `ale_lo_n` goes low and the bus still carries bits 15:0. Both latch strobes stay low until the completion cycle.
- R4: Each word has three phases. The wait phase lasts W+1 cycles, with both strobes high and the bus released. The low phase lasts P+1 cycles. The recovery phase lasts R+1 cycles, with both strobes high. W, P and R are the domain's 8-bit values captured when the request is accepted.
- R5: On a read (`req_write`=0), `rd_n` is low during the low phase and the bus is never driven. The value on `bus_ad_in` at the clock edge that raises `rd_n` appears on `rd_data`, with `rd_valid` high, in the following cycle.
- R6: On a write (`req_write`=1), `wr_n` is low during the low phase, and the bus is driven with the write word for exactly that phase. The word is taken in the last wait cycle, when `wd_ready` is high.
- R7: After the recovery phase of the last word, there is one cycle with `done` high and `done_err` low. Both latch strobes go high in that cycle, and `req_ready` is high from the next cycle on. A count of 0 means 256 words.
- R8: A register write addresses a field with `cfg_addr`. Bit 2 selects the domain (0 = A, 1 = B). Bits 1:0 select the field: 0 = wait, 1 = low time, 2 = recovery. Field code 3 has no effect. A write made during a transfer does not change that transfer's timing.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value and the next read low phase does not start.
- R10: While `wd_valid` is low, a write word's wait phase is extended and `wr_n` stays high.
- R11: After reset, both latch strobes, `rd_n` and `wr_n` are high. The bus is released, `req_ready` is high, and `rd_valid` and `done` are low. Every timing field of both domains holds its parameter default (wait 2, low 3, recovery 1).
- R12: `rd_n` and `wr_n` are never low at the same time, and a strobe is only low while both latch strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_addr | input | 32 | Physical start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_count | input | 8 | Number of words, 0 meaning 256 |
| wd_valid | input | 1 | Write word offered |
| wd_ready | output | 1 | Write word taken this cycle |
| wd_data | input | 16 | Write word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes the read word |
| rd_data | output | 16 | Read word |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a rejected address |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 3 | Domain select and field select |
| cfg_wdata | input | 8 | Timing value |
| bus_ad_out | output | 16 | Value driven on the shared pins |
| bus_ad_oe | output | 1 | Output enable for the shared pins |
| bus_ad_in | input | 16 | Value seen on the shared pins |
| ale_hi_n | output | 1 | Upper address latch strobe, active low |
| ale_lo_n | output | 1 | Lower address latch strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that a requester holds `req_valid` until `req_ready` takes it. They also assume that `rd_ready` and `wd_valid` change only between clock edges, so a stall stays in force for whole cycles. The bench offers a request only after it has seen the sequencer idle, and it raises each request for a single sampled edge. It moves all stream and register inputs on the falling clock edge. Read back-pressure and write starvation are tested in their own dedicated cases. Everywhere else, the consumer always accepts and a write word is always offered. The reference model can therefore predict every cycle without modelling stalls.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int AW   = 32;
  localparam int DW   = 16;
  localparam int TW   = 8;
  localparam int NDOM = 2;
  localparam int DOMW = $clog2(NDOM);

  typedef struct packed {
    logic [TW-1:0] lat;
    logic [TW-1:0] pw;
    logic [TW-1:0] rls;
  } tset_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ERR, S_AH, S_AHL, S_AL, S_ALL, S_LAT, S_LOW, S_REL, S_FIN
  } seq_state_t;

  // address window bounds, inclusive
  localparam logic [AW-1:0] B_LO0 = 32'h0500_0000, B_HI0 = 32'h05FF_FFFF;
  localparam logic [AW-1:0] B_LO1 = 32'h0800_0000, B_HI1 = 32'h0FFF_FFFF;
  localparam logic [AW-1:0] A_LO0 = 32'h0600_0000, A_HI0 = 32'h07FF_FFFF;
  localparam logic [AW-1:0] A_LO1 = 32'h1000_0000, A_HI1 = 32'h1FBF_FFFF;
  localparam logic [AW-1:0] A_LO2 = 32'h1FD0_0000, A_HI2 = 32'h7FFF_FFFF;
endpackage

// File: rtl/pbus_dom_decode.sv
module pbus_dom_decode
  import pbus_pkg::*;
(
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [DOMW-1:0] dom
);
  logic in_b, in_a;

  always_comb begin
    in_b = ((addr >= B_LO0) && (addr <= B_HI0)) ||
           ((addr >= B_LO1) && (addr <= B_HI1));
    in_a = ((addr >= A_LO0) && (addr <= A_HI0)) ||
           ((addr >= A_LO1) && (addr <= A_HI1)) ||
           ((addr >= A_LO2) && (addr <= A_HI2));
    hit  = in_a || in_b;
    dom  = in_b ? DOMW'(1) : DOMW'(0);
  end
endmodule

// File: rtl/pbus_timing_regs.sv
module pbus_timing_regs
  import pbus_pkg::*;
#(
  parameter logic [TW-1:0] DEF_LAT = 8'd2,
  parameter logic [TW-1:0] DEF_PW  = 8'd3,
  parameter logic [TW-1:0] DEF_RLS = 8'd1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [DOMW+1:0]        cfg_addr,
  input  logic [TW-1:0]          cfg_wdata,
  output tset_t [NDOM-1:0]       tsets
);
  logic [DOMW-1:0] sel_dom;
  logic [1:0]      sel_fld;

  assign sel_dom = cfg_addr[DOMW+1:2];
  assign sel_fld = cfg_addr[1:0];

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tsets[d].lat <= DEF_LAT;
        tsets[d].pw  <= DEF_PW;
        tsets[d].rls <= DEF_RLS;
      end else if (cfg_we && (sel_dom == DOMW'(d))) begin
        case (sel_fld)
          2'd0:    tsets[d].lat <= cfg_wdata;
          2'd1:    tsets[d].pw  <= cfg_wdata;
          2'd2:    tsets[d].rls <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pbus_phase_ctr.sv
module pbus_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign hit = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (!hit)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int            CNT_W   = 8,
  parameter logic [TW-1:0] DEF_LAT = 8'd2,
  parameter logic [TW-1:0] DEF_PW  = 8'd3,
  parameter logic [TW-1:0] DEF_RLS = 8'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [CNT_W-1:0] req_count,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [DW-1:0]    wd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_data,
  output logic             done,
  output logic             done_err,
  input  logic             cfg_we,
  input  logic [DOMW+1:0]  cfg_addr,
  input  logic [TW-1:0]    cfg_wdata,
  output logic [DW-1:0]    bus_ad_out,
  output logic             bus_ad_oe,
  input  logic [DW-1:0]    bus_ad_in,
  output logic             ale_hi_n,
  output logic             ale_lo_n,
  output logic             rd_n,
  output logic             wr_n
);
  seq_state_t       state_q, state_d;
  logic [AW-1:0]    addr_q;
  logic             wr_q;
  logic [CNT_W-1:0] left_q;
  tset_t            tim_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             rvalid_q;

  logic             dec_hit;
  logic [DOMW-1:0]  dec_dom;
  tset_t [NDOM-1:0] tsets;
  logic [TW-1:0]    limit;
  logic             hit, go, accept;

  pbus_dom_decode u_dec (
    .addr (req_addr),
    .hit  (dec_hit),
    .dom  (dec_dom)
  );

  pbus_timing_regs #(
    .DEF_LAT (DEF_LAT),
    .DEF_PW  (DEF_PW),
    .DEF_RLS (DEF_RLS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tsets     (tsets)
  );

  always_comb begin
    case (state_q)
      S_LAT:   limit = tim_q.lat;
      S_LOW:   limit = tim_q.pw;
      default: limit = tim_q.rls;
    endcase
  end

  pbus_phase_ctr #(.W(TW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_d != state_q),
    .limit (limit),
    .hit   (hit)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_ready && req_valid;
  // a word may enter its low phase only when its data side can keep up
  assign go        = wr_q ? wd_valid : (!rvalid_q || rd_ready);
  assign wd_ready  = (state_q == S_LAT) && wr_q && hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (req_valid) state_d = dec_hit ? S_AH : S_ERR;
      S_ERR:  state_d = S_IDLE;
      S_AH:   state_d = S_AHL;
      S_AHL:  state_d = S_AL;
      S_AL:   state_d = S_ALL;
      S_ALL:  state_d = S_LAT;
      S_LAT:  if (hit && go) state_d = S_LOW;
      S_LOW:  if (hit) state_d = S_REL;
      S_REL:  if (hit) state_d = (left_q == CNT_W'(1)) ? S_FIN : S_LAT;
      S_FIN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      left_q   <= '0;
      tim_q    <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && dec_hit) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        left_q <= req_count;
        tim_q  <= tsets[dec_dom];
      end
      if ((state_q == S_REL) && hit) left_q <= left_q - 1'b1;
      if (wd_ready && wd_valid) wdata_q <= wd_data;
      if ((state_q == S_LOW) && hit && !wr_q) begin
        rdata_q  <= bus_ad_in;
        rvalid_q <= 1'b1;
      end else if (rd_ready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ale_hi_n   = 1'b1;
    ale_lo_n   = 1'b1;
    rd_n       = 1'b1;
    wr_n       = 1'b1;
    bus_ad_oe  = 1'b0;
    bus_ad_out = '0;
    case (state_q)
      S_AH:  begin bus_ad_oe = 1'b1; bus_ad_out = addr_q[AW-1:DW]; end
      S_AHL: begin bus_ad_oe = 1'b1; bus_ad_out = addr_q[AW-1:DW]; ale_hi_n = 1'b0; end
      S_AL:  begin bus_ad_oe = 1'b1; bus_ad_out = addr_q[DW-1:0];  ale_hi_n = 1'b0; end
      S_ALL: begin
        bus_ad_oe = 1'b1; bus_ad_out = addr_q[DW-1:0];
        ale_hi_n  = 1'b0; ale_lo_n   = 1'b0;
      end
      S_LAT, S_REL: begin ale_hi_n = 1'b0; ale_lo_n = 1'b0; end
      S_LOW: begin
        ale_hi_n = 1'b0;
        ale_lo_n = 1'b0;
        rd_n     = wr_q;
        wr_n     = !wr_q;
        if (wr_q) begin
          bus_ad_oe  = 1'b1;
          bus_ad_out = wdata_q;
        end
      end
      default: ;
    endcase
  end

  assign done     = (state_q == S_FIN) || (state_q == S_ERR);
  assign done_err = (state_q == S_ERR);
  assign rd_valid = rvalid_q;
  assign rd_data  = rdata_q;
endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        ale_hi_n,
  input logic        ale_lo_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        bus_ad_oe,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [15:0] rd_data,
  input logic        done,
  input logic        done_err
);
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_strobe_framed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!ale_hi_n && !ale_lo_n));

  assert_latch_nest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_lo_n |-> !ale_hi_n);

  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_ad_oe);

  assert_write_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_ad_oe);

  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> (done && ale_hi_n && $past(ale_hi_n) && !bus_ad_oe));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ale_hi_n && ale_lo_n));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_rd_nostrobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> rd_n);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ale_hi_n && ale_lo_n && rd_n && wr_n));

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);
endmodule

bind pbus_seq pbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ale_hi_n  (ale_hi_n),
  .ale_lo_n  (ale_lo_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .bus_ad_oe (bus_ad_oe),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .done      (done),
  .done_err  (done_err)
);

// File: tb/pbus_seq_test.sv
`timescale 1ns/100ps
module pbus_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_count = 8'd1;
  logic        wd_valid = 1'b1;
  logic        wd_ready;
  logic [15:0] wd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        done, done_err;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic        ale_hi_n, ale_lo_n, rd_n, wr_n;

  always #2.5 clk = ~clk;

  pbus_seq uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_count(req_count),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .done_err(done_err),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .ale_hi_n(ale_hi_n), .ale_lo_n(ale_lo_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  int vectors = 0;
  int fails = 0;
  string cur_tag = "R4";
  bit model_on = 1'b0;

  // expected item: ready done err ahn aln rdn wrn oe data[15:0]
  logic [23:0] expq[$];
  logic [15:0] rdq[$];
  int tlat[2], tpw[2], trls[2];
  int exp_wr = 0, exp_rd = 0;
  int rd_idx = 0;
  logic prev_rdn = 1'b1;
  logic [15:0] wr_idx = '0;

  assign wd_data = 16'h5000 + wr_idx;
  always @(posedge clk) if (wd_valid && wd_ready) wr_idx <= wr_idx + 16'd1;

  // slave model: presents a new word after each read strobe rising edge
  always @(negedge clk) begin
    if (!prev_rdn && rd_n) rd_idx++;
    prev_rdn  = rd_n;
    bus_ad_in = 16'hA000 + 16'(rd_idx);
  end

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s/%s %s: actual %0h expected %0h", tag, cur_tag, what, act, expv);
    end
  endtask

  function automatic logic [23:0] mk(bit rdy, bit dn, bit er, bit ahn, bit aln,
                                      bit rdn, bit wrn, bit oe, logic [15:0] d);
    return {rdy, dn, er, ahn, aln, rdn, wrn, oe, d};
  endfunction

  function automatic int dom_of(logic [31:0] a);
    if ((a >= 32'h0500_0000 && a <= 32'h05FF_FFFF) ||
        (a >= 32'h0800_0000 && a <= 32'h0FFF_FFFF)) return 1;
    if ((a >= 32'h0600_0000 && a <= 32'h07FF_FFFF) ||
        (a >= 32'h1000_0000 && a <= 32'h1FBF_FFFF) ||
        (a >= 32'h1FD0_0000 && a <= 32'h7FFF_FFFF)) return 0;
    return -1;
  endfunction

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (model_on) begin
      logic [23:0] e;
      e = (expq.size() != 0) ? expq.pop_front() : mk(1,0,0,1,1,1,1,0,16'h0);
      chk(req_ready == e[23], "R7", "req_ready", req_ready, e[23]);
      chk(done == e[22], "R7", "done", done, e[22]);
      chk(done_err == e[21], "R2", "done_err", done_err, e[21]);
      chk(ale_hi_n == e[20], "R3", "ale_hi_n", ale_hi_n, e[20]);
      chk(ale_lo_n == e[19], "R3", "ale_lo_n", ale_lo_n, e[19]);
      chk(rd_n == e[18], "R4", "rd_n", rd_n, e[18]);
      chk(wr_n == e[17], "R4", "wr_n", wr_n, e[17]);
      chk(bus_ad_oe == e[16], "R5", "bus_ad_oe", bus_ad_oe, e[16]);
      if (e[16]) chk(bus_ad_out == e[15:0], "R6", "bus_ad_out", bus_ad_out, e[15:0]);
      if (rd_valid) begin
        if (rdq.size() == 0) chk(1'b0, "R5", "unexpected rd_valid", 1, 0);
        else begin
          logic [15:0] r;
          r = rdq.pop_front();
          chk(rd_data == r, "R5", "rd_data", rd_data, r);
        end
      end
    end
  end

  task automatic push_xfer(logic [31:0] a, bit wr, int cnt);
    int d;
    d = dom_of(a);
    if (d < 0) begin
      expq.push_back(mk(0,1,1,1,1,1,1,0,16'h0));
      return;
    end
    expq.push_back(mk(0,0,0,1,1,1,1,1,a[31:16]));
    expq.push_back(mk(0,0,0,0,1,1,1,1,a[31:16]));
    expq.push_back(mk(0,0,0,0,1,1,1,1,a[15:0]));
    expq.push_back(mk(0,0,0,0,0,1,1,1,a[15:0]));
    for (int w = 0; w < cnt; w++) begin
      for (int i = 0; i <= tlat[d]; i++) expq.push_back(mk(0,0,0,0,0,1,1,0,16'h0));
      for (int i = 0; i <= tpw[d]; i++)
        expq.push_back(mk(0,0,0,0,0,wr,!wr,wr, wr ? 16'h5000 + 16'(exp_wr) : 16'h0));
      if (wr) exp_wr++;
      else begin rdq.push_back(16'hA000 + 16'(exp_rd)); exp_rd++; end
      for (int i = 0; i <= trls[d]; i++) expq.push_back(mk(0,0,0,0,0,1,1,0,16'h0));
    end
    expq.push_back(mk(0,1,0,1,1,1,1,0,16'h0));
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk); #0.5;
      if (expq.size() == 0 && req_ready) break;
    end
  endtask

  task automatic request(logic [31:0] a, bit wr, int cnt, bit model);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_count = 8'(cnt);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (model) push_xfer(a, wr, cnt);
  endtask

  task automatic cfg(int dom, int fld, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {1'(dom), 2'(fld)}; cfg_wdata = 8'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (fld == 0) tlat[dom] = val;
    if (fld == 1) tpw[dom]  = val;
    if (fld == 2) trls[dom] = val;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin tlat[d] = 2; tpw[d] = 3; trls[d] = 1; end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(ale_hi_n && ale_lo_n && rd_n && wr_n, "R11", "strobes in reset", 0, 1);
    chk(!bus_ad_oe && req_ready === 1'b1 && !rd_valid && !done, "R11", "idle outputs", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    model_on = 1'b1;

    cur_tag = "R11"; request(32'h1000_1234, 0, 2, 1); wait_idle();   // defaults, read
    cur_tag = "R6";  request(32'h1000_0040, 1, 3, 1); wait_idle();   // write
    cur_tag = "R1";
    cfg(1, 0, 0); cfg(1, 1, 0); cfg(1, 2, 0);
    request(32'h0800_0010, 1, 2, 1); wait_idle();
    request(32'h0500_0200, 0, 3, 1); wait_idle();
    request(32'h0FFF_FFFE, 0, 1, 1); wait_idle();
    request(32'h0600_0000, 0, 1, 1); wait_idle();
    request(32'h1FD0_0000, 1, 1, 1); wait_idle();
    request(32'h7FFF_FFF0, 0, 1, 1); wait_idle();
    cur_tag = "R2";
    request(32'h1FC0_0000, 0, 2, 1); wait_idle();
    request(32'h1FCF_FFFF, 1, 2, 1); wait_idle();
    request(32'h04FF_FFFF, 0, 1, 1); wait_idle();
    request(32'h8000_0000, 1, 1, 1); wait_idle();
    cur_tag = "R8";
    cfg(0, 3, 9);                                  // field code 3: no effect
    request(32'h1000_0000, 0, 1, 1); wait_idle();
    cfg(0, 0, 5); cfg(0, 1, 1); cfg(0, 2, 4);
    request(32'h0700_0000, 1, 2, 1);
    cfg(0, 1, 6);                                  // mid-transfer write, no effect on it
    wait_idle();
    request(32'h0700_0100, 0, 2, 1); wait_idle();  // new low time in force
    cur_tag = "R4";
    request(32'h0500_0000, 1, 4, 1); wait_idle();

    // R9: read back-pressure
    model_on = 1'b0;
    begin
      int r0, lows;
      r0 = rd_idx; lows = 0;
      @(negedge clk); rd_ready = 1'b0;
      request(32'h0500_0000, 0, 2, 0);
      for (int i = 0; i < 60 && !rd_valid; i++) @(negedge clk);
      chk(rd_valid == 1'b1, "R9", "first read word valid", rd_valid, 1);
      chk(rd_data == 16'hA000 + 16'(r0), "R9", "first read word", rd_data, 16'hA000 + 16'(r0));
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!rd_n) lows++;
      end
      chk(lows == 0, "R9", "read strobe during stall", lows, 0);
      chk(rd_valid && rd_data == 16'hA000 + 16'(r0), "R9", "held word", rd_data, 16'hA000 + 16'(r0));
      rd_ready = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 60 && !rd_valid; i++) @(negedge clk);
      chk(rd_data == 16'hA000 + 16'(r0 + 1), "R9", "second read word", rd_data, 16'hA000 + 16'(r0 + 1));
      for (int i = 0; i < 60 && !req_ready; i++) @(negedge clk);
    end

    // R10: write starvation
    begin
      int lows;
      logic [15:0] w0;
      lows = 0; w0 = wr_idx;
      wd_valid = 1'b0;
      request(32'h0800_0000, 1, 1, 0);
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!wr_n) lows++;
      end
      chk(lows == 0, "R10", "write strobe while starved", lows, 0);
      wd_valid = 1'b1;
      for (int i = 0; i < 20 && wr_n; i++) @(negedge clk);
      chk(!wr_n && bus_ad_oe && bus_ad_out == 16'h5000 + w0, "R10", "write word after release",
          bus_ad_out, 16'h5000 + w0);
      for (int i = 0; i < 60 && !req_ready; i++) @(negedge clk);
    end
    exp_wr = int'(wr_idx - 16'h0000);
    exp_rd = rd_idx;
    rdq.delete();

    // R12 / R7: back-to-back requests after return to model
    cur_tag = "R12";
    @(negedge clk); model_on = 1'b1;
    request(32'h0800_0002, 0, 1, 1); wait_idle();
    request(32'h1000_0002, 1, 1, 1); wait_idle();

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule